// File: doc/BRIEF.md
# Per-Sector NAND ECC Read Sequencer

This block orders the flash accesses for a page read that uses a hardware BCH engine. The page is split into 512-byte sectors. For each sector it issues a data-read command at that sector's column and re-arms the ECC engine. It then takes the 512 data bytes. Next it issues one or two spare-area read commands at the places where that sector's 13 ECC bytes are stored, and takes those bytes straight after the data, because the decoder produces error offsets only from that back-to-back order. Last, it asks the correction logic for a result and adds it to the page statistics.

The command, address and byte interfaces are abstract handshakes. A command is a kind (data or spare), a column and a byte length, held until the flash side accepts it. Each byte is one `byte_valid` beat while `byte_ready` is high. The correction result is a signed number: a negative value means the sector could not be corrected, and zero or more is the count of bits that were fixed. The layout mode (large page or 512-byte page) and the bus width are sampled when a page starts.

Top module: `nand_ecc_rdseq`

## Requirements
- R1: After reset the block is idle: `busy`, `cmd_valid`, `byte_ready`, `corr_req`, `ecc_arm` and `done` are low, and both statistics counters read zero.
- R2: For sector s (counting from 0, in rising order), the block issues a data command with `cmd_kind`=0, `cmd_col`=s*512 and `cmd_len`=512, and shows s on `sector_idx`.
- R3: `ecc_arm` is a one-cycle pulse in the cycle right after each data-command handshake. There is exactly one pulse per sector and none at any other time.
- R4: After a data command the block takes exactly 512 bytes, then exactly `cmd_len` bytes after each spare command, before it issues its next command or correction request. `byte_ready` is high only while bytes are owed.
- R5: In large-page mode (`small_page`=0 at start), sector s has one spare command with `cmd_kind`=1, `cmd_col`=2+16*s and `cmd_len`=13.
- R6: In 512-byte-page mode (`small_page`=1 at start), the page has exactly one sector, whatever `num_sectors` holds. Its ECC is read with two spare commands in order: column 0 with length 4, then column 6 with length 9. `small_page` and `bus16` are sampled only when a page starts.
- R7: With `bus16`=1 at start, every odd spare length is rounded up by one: 14 in large-page mode, and 4 then 10 in 512-byte-page mode.
- R8: `corr_req` rises only after the last spare byte of a sector. When `corr_done` is accepted, a negative `corr_result` (two's complement) adds one to `failed_cnt`; otherwise `corr_result` is added to `corrected_cnt`. The counters change at no other time, except for the clear in R10.
- R9: The sectors per page are `num_sectors`, clamped to 1..16 (0 reads as 1, above 16 reads as 16). `done` is a one-cycle pulse after the last sector's correction, and `busy` is low from that cycle on.
- R10: A command holds its kind, column and length until `cmd_ready`. `start` is ignored while busy. Both counters clear when a page starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a page read (taken only when idle) |
| num_sectors | input | 5 | Sectors per page, clamped to 1..16 |
| small_page | input | 1 | 1: 512-byte-page layout with split ECC |
| bus16 | input | 1 | 1: 16-bit bus, round spare lengths up to even |
| cmd_valid | output | 1 | Command pending |
| cmd_ready | input | 1 | Flash side accepts the command |
| cmd_kind | output | 1 | 0: data read, 1: spare-area read |
| cmd_col | output | 16 | Column (data) or spare offset (spare) |
| cmd_len | output | 10 | Bytes to transfer for this command |
| ecc_arm | output | 1 | Re-arm pulse for the ECC engine |
| byte_ready | output | 1 | Block is taking bytes |
| byte_valid | input | 1 | One byte delivered this cycle |
| corr_req | output | 1 | Correction requested for the current sector |
| corr_done | input | 1 | Correction result valid |
| corr_result | input | 8 | Signed result: negative means failed, else bits fixed |
| corrected_cnt | output | 12 | Sum of corrected bits in this page |
| failed_cnt | output | 5 | Uncorrectable sectors in this page |
| sector_idx | output | 4 | Current sector number |
| busy | output | 1 | Page read in progress |
| done | output | 1 | One-cycle end-of-page pulse |

## Verification
The sequence is tried with several kinds of page. A single large-page sector isolates the per-sector order. A full 16-sector page with a 16-bit bus shows that the spare stride and the rounding advance with the sector number. The two split-ECC pages show the two-piece order and that a page in that mode is cut to one sector. Zero and out-of-range sector counts exercise the clamp. Random pages vary the stall timing on every handshake, so a data/ECC misorder or a miscounted byte shows up as a command at the wrong moment. The `small_page`/`bus16` inputs are flipped after each start and stray `start` pulses are sent mid-page; these tell apart a block that latches its mode and a block that keeps following its live inputs. Mixed negative and non-negative correction results separate the failed and corrected paths.

// File: rtl/nrs_pkg.sv
// Shared types of the NAND ECC read sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package nrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CMD_DATA  = 3'd1,
        ST_XFER_DATA = 3'd2,
        ST_CMD_OOB   = 3'd3,
        ST_XFER_OOB  = 3'd4,
        ST_CORRECT   = 3'd5,
        ST_NEXT      = 3'd6
    } seq_state_t;

    localparam logic KIND_DATA  = 1'b0;
    localparam logic KIND_SPARE = 1'b1;
endpackage

// File: rtl/nrs_place.sv
// Works out where the ECC of the current sector sits and how long each
// command is. Large-page mode uses one strided piece per sector.
// Small-page mode uses two pieces around the bad-block marker bytes.
// On a 16-bit bus, odd lengths are rounded up to even.
// Assumes: sector and piece are stable while a command or transfer runs.
module nrs_place #(
    parameter int SECTOR_BYTES = 512,
    parameter int ECC_BYTES    = 13,
    parameter int SPARE_BASE   = 2,
    parameter int SPARE_STRIDE = 16,
    parameter int SP_LEN0      = 4,
    parameter int SP_OFF1      = 6,
    parameter int COL_W        = 16,
    parameter int LEN_W        = 10,
    parameter int SECT_W       = 4
) (
    input  logic [SECT_W-1:0] sector,
    input  logic              piece,
    input  logic              small_page,
    input  logic              bus16,
    output logic [COL_W-1:0]  data_col,
    output logic [COL_W-1:0]  spare_col,
    output logic [LEN_W-1:0]  spare_len,
    output logic              last_piece
);
    localparam int SP_LEN1 = ECC_BYTES - SP_LEN0;

    logic [LEN_W-1:0] raw_len;

    // Data column of the sector.
    always_comb begin
        data_col = COL_W'(sector) * COL_W'(SECTOR_BYTES);
    end

    // Spare offset and raw length of the current piece.
    always_comb begin
        if (!small_page) begin
            raw_len   = LEN_W'(ECC_BYTES);
            spare_col = COL_W'(SPARE_BASE) + COL_W'(SPARE_STRIDE) * COL_W'(sector);
        end else if (!piece) begin
            raw_len   = LEN_W'(SP_LEN0);
            spare_col = '0;
        end else begin
            raw_len   = LEN_W'(SP_LEN1);
            spare_col = COL_W'(SP_OFF1);
        end
    end

    // Round odd lengths up to even on a 16-bit bus.
    always_comb begin
        if (bus16 && raw_len[0]) begin
            spare_len = raw_len + LEN_W'(1);
        end else begin
            spare_len = raw_len;
        end
    end

    // The last piece ends the spare reads of a sector.
    always_comb begin
        last_piece = !small_page || piece;
    end
endmodule

// File: rtl/nrs_stats.sv
// Adds up the correction results of a page: one more failed sector for a
// negative result, otherwise the result is added to the corrected-bit sum.
// Assumes: CORR_W is wide enough for 16 sectors of the largest positive result.
module nrs_stats #(
    parameter int RES_W  = 8,
    parameter int CORR_W = 12,
    parameter int FAIL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [RES_W-1:0]  result,
    output logic [CORR_W-1:0] corrected,
    output logic [FAIL_W-1:0] failed
);
    // Counter update: clear at page start, add at each correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corrected <= '0;
            failed    <= '0;
        end else if (clr) begin
            corrected <= '0;
            failed    <= '0;
        end else if (take) begin
            if (result[RES_W-1]) begin
                failed <= failed + FAIL_W'(1);
            end else begin
                corrected <= corrected + CORR_W'(result);
            end
        end
    end
endmodule

// File: rtl/nrs_fsm.sv
// Runs the per-sector order: data command, arm, data bytes, then one spare
// command with its bytes per piece, then correction. This repeats until the
// last sector. The page mode and the sector count are latched at start.
// Assumes: the handshake inputs are synchronous to clk.
module nrs_fsm
    import nrs_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int MAX_SECT     = 16,
    parameter int SECT_W       = 4,
    parameter int NS_W         = 5,
    parameter int LEN_W        = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NS_W-1:0]   num_sectors,
    input  logic              small_page,
    input  logic              bus16,
    input  logic              cmd_ready,
    input  logic              byte_valid,
    input  logic              corr_done,
    input  logic [LEN_W-1:0]  spare_len,
    input  logic              last_piece,
    output seq_state_t        state,
    output logic [SECT_W-1:0] sector,
    output logic              piece,
    output logic              mode_small,
    output logic              mode_b16,
    output logic              ecc_arm,
    output logic              done,
    output logic              stats_clr,
    output logic              stats_take
);
    seq_state_t        nxt;
    logic [LEN_W-1:0]  byte_cnt;
    logic [SECT_W-1:0] last_sect;
    logic              data_end;
    logic              piece_end;
    logic              at_last;

    // Turn the requested count into the index of the last sector, clamped to 1..MAX_SECT.
    function automatic logic [SECT_W-1:0] last_of(input logic [NS_W-1:0] n);
        if (n == '0) begin
            return '0;
        end else if (n > NS_W'(MAX_SECT)) begin
            return SECT_W'(MAX_SECT - 1);
        end else begin
            return SECT_W'(n - NS_W'(1));
        end
    endfunction

    // Transfer end conditions and the last-sector flag.
    always_comb begin
        data_end  = (state == ST_XFER_DATA) && byte_valid &&
                    (byte_cnt == LEN_W'(SECTOR_BYTES - 1));
        piece_end = (state == ST_XFER_OOB) && byte_valid &&
                    (byte_cnt == spare_len - LEN_W'(1));
        at_last   = (sector == last_sect);
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start)      nxt = ST_CMD_DATA;
            ST_CMD_DATA:  if (cmd_ready)  nxt = ST_XFER_DATA;
            ST_XFER_DATA: if (data_end)   nxt = ST_CMD_OOB;
            ST_CMD_OOB:   if (cmd_ready)  nxt = ST_XFER_OOB;
            ST_XFER_OOB:  if (piece_end)  nxt = last_piece ? ST_CORRECT : ST_CMD_OOB;
            ST_CORRECT:   if (corr_done)  nxt = ST_NEXT;
            ST_NEXT:      nxt = at_last ? ST_IDLE : ST_CMD_DATA;
            default:      nxt = ST_IDLE;
        endcase
    end

    // Strobes for the statistics unit.
    always_comb begin
        stats_clr  = (state == ST_IDLE) && start;
        stats_take = (state == ST_CORRECT) && corr_done;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Page mode and sector count latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_small <= 1'b0;
            mode_b16   <= 1'b0;
            last_sect  <= '0;
        end else if (state == ST_IDLE && start) begin
            mode_small <= small_page;
            mode_b16   <= bus16;
            last_sect  <= small_page ? '0 : last_of(num_sectors);
        end
    end

    // Sector counter, stepped after each correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sector <= '0;
        end else if (state == ST_IDLE && start) begin
            sector <= '0;
        end else if (state == ST_NEXT && !at_last) begin
            sector <= sector + SECT_W'(1);
        end
    end

    // Piece index within the spare reads of a sector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            piece <= 1'b0;
        end else if (state == ST_CMD_DATA) begin
            piece <= 1'b0;
        end else if (piece_end && !last_piece) begin
            piece <= 1'b1;
        end
    end

    // Byte counter, cleared at each command handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= '0;
        end else if ((state == ST_CMD_DATA || state == ST_CMD_OOB) && cmd_ready) begin
            byte_cnt <= '0;
        end else if ((state == ST_XFER_DATA || state == ST_XFER_OOB) && byte_valid) begin
            byte_cnt <= byte_cnt + LEN_W'(1);
        end
    end

    // Arm pulse after the data command, and the end-of-page pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_arm <= 1'b0;
            done    <= 1'b0;
        end else begin
            ecc_arm <= (state == ST_CMD_DATA) && cmd_ready;
            done    <= (state == ST_NEXT) && at_last;
        end
    end
endmodule

// File: rtl/nand_ecc_rdseq.sv
// Top of the per-sector NAND ECC read sequencer. It ties together the order
// controller, the spare placement logic and the page statistics, and drives
// the abstract command, byte and correction handshakes.
// Assumes: the flash side holds cmd_ready/byte_valid meaning for one cycle each.
module nand_ecc_rdseq
    import nrs_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ECC_BYTES    = 13,
    parameter int SPARE_BASE   = 2,
    parameter int SPARE_STRIDE = 16,
    parameter int SP_LEN0      = 4,
    parameter int SP_OFF1      = 6,
    parameter int MAX_SECT     = 16,
    parameter int COL_W        = 16,
    parameter int RES_W        = 8,
    parameter int CORR_W       = 12,
    parameter int FAIL_W       = 5,
    localparam int SECT_W      = $clog2(MAX_SECT),
    localparam int NS_W        = $clog2(MAX_SECT + 1),
    localparam int LEN_W       = $clog2(SECTOR_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NS_W-1:0]   num_sectors,
    input  logic              small_page,
    input  logic              bus16,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_kind,
    output logic [COL_W-1:0]  cmd_col,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              ecc_arm,
    output logic              byte_ready,
    input  logic              byte_valid,
    output logic              corr_req,
    input  logic              corr_done,
    input  logic [RES_W-1:0]  corr_result,
    output logic [CORR_W-1:0] corrected_cnt,
    output logic [FAIL_W-1:0] failed_cnt,
    output logic [SECT_W-1:0] sector_idx,
    output logic              busy,
    output logic              done
);
    seq_state_t        state;
    logic [SECT_W-1:0] sector;
    logic              piece;
    logic              mode_small;
    logic              mode_b16;
    logic              stats_clr;
    logic              stats_take;
    logic [COL_W-1:0]  data_col;
    logic [COL_W-1:0]  spare_col;
    logic [LEN_W-1:0]  spare_len;
    logic              last_piece;

    nrs_fsm #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .MAX_SECT    (MAX_SECT),
        .SECT_W      (SECT_W),
        .NS_W        (NS_W),
        .LEN_W       (LEN_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .num_sectors(num_sectors),
        .small_page (small_page),
        .bus16      (bus16),
        .cmd_ready  (cmd_ready),
        .byte_valid (byte_valid),
        .corr_done  (corr_done),
        .spare_len  (spare_len),
        .last_piece (last_piece),
        .state      (state),
        .sector     (sector),
        .piece      (piece),
        .mode_small (mode_small),
        .mode_b16   (mode_b16),
        .ecc_arm    (ecc_arm),
        .done       (done),
        .stats_clr  (stats_clr),
        .stats_take (stats_take)
    );

    nrs_place #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .ECC_BYTES   (ECC_BYTES),
        .SPARE_BASE  (SPARE_BASE),
        .SPARE_STRIDE(SPARE_STRIDE),
        .SP_LEN0     (SP_LEN0),
        .SP_OFF1     (SP_OFF1),
        .COL_W       (COL_W),
        .LEN_W       (LEN_W),
        .SECT_W      (SECT_W)
    ) u_place (
        .sector    (sector),
        .piece     (piece),
        .small_page(mode_small),
        .bus16     (mode_b16),
        .data_col  (data_col),
        .spare_col (spare_col),
        .spare_len (spare_len),
        .last_piece(last_piece)
    );

    nrs_stats #(
        .RES_W (RES_W),
        .CORR_W(CORR_W),
        .FAIL_W(FAIL_W)
    ) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stats_clr),
        .take     (stats_take),
        .result   (corr_result),
        .corrected(corrected_cnt),
        .failed   (failed_cnt)
    );

    // Command fields, chosen by the phase.
    always_comb begin
        cmd_valid = (state == ST_CMD_DATA) || (state == ST_CMD_OOB);
        cmd_kind  = (state == ST_CMD_OOB) ? KIND_SPARE : KIND_DATA;
        cmd_col   = (state == ST_CMD_OOB) ? spare_col : data_col;
        cmd_len   = (state == ST_CMD_OOB) ? spare_len : LEN_W'(SECTOR_BYTES);
    end

    // Transfer, correction and status outputs.
    always_comb begin
        byte_ready = (state == ST_XFER_DATA) || (state == ST_XFER_OOB);
        corr_req   = (state == ST_CORRECT);
        busy       = (state != ST_IDLE);
        sector_idx = sector;
    end
endmodule

// File: rtl/nrs_checker.sv
// Properties over the ports of the sequencer. Bound to every instance.
// Assumes: synchronous active-low reset.
module nrs_checker #(
    parameter int SECTOR_BYTES = 512,
    parameter int ECC_BYTES    = 13,
    parameter int SPARE_BASE   = 2,
    parameter int SPARE_STRIDE = 16,
    parameter int COL_W        = 16,
    parameter int LEN_W        = 10,
    parameter int CORR_W       = 12,
    parameter int FAIL_W       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_kind,
    input logic [COL_W-1:0]  cmd_col,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              ecc_arm,
    input logic              corr_req,
    input logic              corr_done,
    input logic              done,
    input logic [CORR_W-1:0] corrected_cnt,
    input logic [FAIL_W-1:0] failed_cnt
);
    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) &&
                                    $stable(cmd_col) && $stable(cmd_len));

    p_arm_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_arm |-> $past(cmd_valid && cmd_ready && !cmd_kind));

    p_arm_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_arm |=> !ecc_arm);

    p_data_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_kind |->
            (cmd_col % COL_W'(SECTOR_BYTES)) == '0 && cmd_len == LEN_W'(SECTOR_BYTES));

    p_spare_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind && cmd_len >= LEN_W'(ECC_BYTES) |->
            (cmd_col % COL_W'(SPARE_STRIDE)) == COL_W'(SPARE_BASE));

    p_stats_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(corr_req && corr_done) && !$past(start && !busy) |->
            $stable(corrected_cnt) && $stable(failed_cnt));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);
endmodule

bind nand_ecc_rdseq nrs_checker #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .ECC_BYTES   (ECC_BYTES),
    .SPARE_BASE  (SPARE_BASE),
    .SPARE_STRIDE(SPARE_STRIDE),
    .COL_W       (COL_W),
    .LEN_W       (LEN_W),
    .CORR_W      (CORR_W),
    .FAIL_W      (FAIL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_kind     (cmd_kind),
    .cmd_col      (cmd_col),
    .cmd_len      (cmd_len),
    .ecc_arm      (ecc_arm),
    .corr_req     (corr_req),
    .corr_done    (corr_done),
    .done         (done),
    .corrected_cnt(corrected_cnt),
    .failed_cnt   (failed_cnt)
);

// File: tb/nand_ecc_rdseq_test.sv
`timescale 1ns/1ps
module nand_ecc_rdseq_test;
    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [4:0]        num_sectors;
    logic              small_page;
    logic              bus16;
    logic              cmd_valid;
    logic              cmd_ready;
    logic              cmd_kind;
    logic [15:0]       cmd_col;
    logic [9:0]        cmd_len;
    logic              ecc_arm;
    logic              byte_ready;
    logic              byte_valid;
    logic              corr_req;
    logic              corr_done;
    logic [7:0]        corr_result;
    logic [11:0]       corrected_cnt;
    logic [4:0]        failed_cnt;
    logic [3:0]        sector_idx;
    logic              busy;
    logic              done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    nand_ecc_rdseq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_sectors(num_sectors),
        .small_page(small_page), .bus16(bus16), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_col(cmd_col),
        .cmd_len(cmd_len), .ecc_arm(ecc_arm), .byte_ready(byte_ready),
        .byte_valid(byte_valid), .corr_req(corr_req), .corr_done(corr_done),
        .corr_result(corr_result), .corrected_cnt(corrected_cnt),
        .failed_cnt(failed_cnt), .sector_idx(sector_idx), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected sector count (R6, R9).
    function automatic int exp_sectors(input int ns, input bit sp);
        if (sp) return 1;
        if (ns < 1) return 1;
        if (ns > 16) return 16;
        return ns;
    endfunction

    // Expected spare offset (R5, R6).
    function automatic int exp_off(input bit sp, input int s, input int p);
        if (!sp) return 2 + 16 * s;
        return (p == 0) ? 0 : 6;
    endfunction

    // Expected spare length (R5, R6, R7).
    function automatic int exp_len(input bit sp, input bit b16, input int p);
        int raw;
        raw = sp ? ((p == 0) ? 4 : 9) : 13;
        if (b16 && (raw % 2 == 1)) raw = raw + 1;
        return raw;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; cmd_ready = 1'b0; byte_valid = 1'b0;
        corr_done = 1'b0; corr_result = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One page: responder and reference model. res_kind: 0 mixed, 1 all fail, 2 all pass.
    task automatic run_page(input int ns, input bit sp, input bit b16, input int res_kind);
        int nsec, np, sec, pc, phase, bytes, need, arms, cyc, exp_corr, exp_fail, r;
        bit arm_due, fin, bad;
        string lreq;
        nsec = exp_sectors(ns, sp);
        np = sp ? 2 : 1;
        sec = 0; pc = 0; phase = 0; bytes = 0; need = 0; arms = 0; cyc = 0;
        exp_corr = 0; exp_fail = 0; arm_due = 0; fin = 0; bad = 0;
        lreq = sp ? "R6" : "R5";
        if (b16) lreq = "R7";
        num_sectors = 5'(ns); small_page = sp; bus16 = b16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        small_page = ~sp; bus16 = ~b16;   // latched at start (R6)
        chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
        chk(corrected_cnt == 0 && failed_cnt == 0, "R10 counters cleared at start",
            int'(corrected_cnt) + int'(failed_cnt), 0);
        while (!fin) begin
            if (ecc_arm) begin
                arms++;
                if (!arm_due) chk(1'b0, "R3 arm without data command", 1, 0);
            end else if (arm_due) begin
                chk(1'b0, "R3 arm missing", 0, 1);
            end
            arm_due = 0;
            cmd_ready = 1'b0; byte_valid = 1'b0; corr_done = 1'b0; start = 1'b0;
            if (done) begin
                fin = 1;
                chk(phase == 5, "R9 done before all sectors", sec, nsec);
                chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
                chk(int'(corrected_cnt) == exp_corr, "R8 corrected sum", int'(corrected_cnt), exp_corr);
                chk(int'(failed_cnt) == exp_fail, "R8 failed count", int'(failed_cnt), exp_fail);
                chk(arms == nsec, "R3 arm count", arms, nsec);
            end else if (cmd_valid) begin
                if ($urandom % 4 != 0) begin
                    cmd_ready = 1'b1;
                    if (phase == 0) begin
                        chk(cmd_kind == 1'b0 && int'(cmd_col) == sec * 512 && cmd_len == 10'd512
                            && int'(sector_idx) == sec, "R2 data command column", int'(cmd_col), sec * 512);
                        phase = 1; bytes = 0; need = 512; arm_due = 1;
                    end else if (phase == 2) begin
                        chk(cmd_kind == 1'b1 && int'(cmd_col) == exp_off(sp, sec, pc),
                            {lreq, " spare column"}, int'(cmd_col), exp_off(sp, sec, pc));
                        chk(int'(cmd_len) == exp_len(sp, b16, pc), {lreq, " spare length"},
                            int'(cmd_len), exp_len(sp, b16, pc));
                        phase = 3; bytes = 0; need = exp_len(sp, b16, pc);
                    end else begin
                        chk(1'b0, "R4 command while bytes owed", bytes, need); bad = 1; fin = 1;
                    end
                end
            end else if (byte_ready) begin
                if (phase != 1 && phase != 3) begin
                    chk(1'b0, "R4 extra byte requested", bytes, need); bad = 1; fin = 1;
                end else if ($urandom % 8 != 0) begin
                    byte_valid = 1'b1; bytes++;
                    if (bytes == need) begin
                        if (phase == 1) phase = 2;
                        else begin pc++; phase = (pc == np) ? 4 : 2; end
                    end
                end
            end else if (corr_req) begin
                if (phase != 4) begin
                    chk(1'b0, "R8 correction before spare bytes done", phase, 4); bad = 1; fin = 1;
                end else if ($urandom % 3 != 0) begin
                    if (res_kind == 1 || (res_kind == 0 && $urandom % 4 == 0)) r = -1 - int'($urandom % 4);
                    else r = int'($urandom % 9);
                    corr_done = 1'b1; corr_result = 8'(r);
                    if (r < 0) exp_fail++; else exp_corr += r;
                    sec++; pc = 0; phase = (sec == nsec) ? 5 : 0;
                end
            end else if (!busy) begin
                chk(1'b0, "R9 idle without done", sec, nsec); bad = 1; fin = 1;
            end
            if (!fin && busy && $urandom % 64 == 0) start = 1'b1;   // R10 ignored while busy
            @(negedge clk);
            cyc++;
            if (!fin && cyc > 40000) begin
                chk(1'b0, "R9 page did not finish", cyc, 40000); bad = 1; fin = 1;
            end
        end
        cmd_ready = 1'b0; byte_valid = 1'b0; corr_done = 1'b0; start = 1'b0;
        if (bad) begin
            do_reset();
        end else begin
            chk(done == 1'b0 && busy == 1'b0, "R9 done is one cycle", int'(done), 0);
            chk(ecc_arm == 1'b0 && cmd_valid == 1'b0, "R3 quiet after page", int'(ecc_arm), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        num_sectors = 5'd1; small_page = 1'b0; bus16 = 1'b0;
        do_reset();
        // R1 reset state
        chk(busy == 0 && cmd_valid == 0 && byte_ready == 0 && corr_req == 0 && done == 0
            && ecc_arm == 0, "R1 idle outputs", int'(busy), 0);
        chk(corrected_cnt == 0 && failed_cnt == 0, "R1 counters zero",
            int'(corrected_cnt) + int'(failed_cnt), 0);
        // Directed corners
        run_page(1, 1'b0, 1'b0, 2);    // R2 R5 single sector
        run_page(16, 1'b0, 1'b1, 0);   // R7 full page, 16-bit
        run_page(3, 1'b1, 1'b0, 1);    // R6 split ECC, all failing
        run_page(9, 1'b1, 1'b1, 0);    // R6 R7 split ECC rounded
        run_page(0, 1'b0, 1'b0, 0);    // R9 zero clamps to one
        run_page(25, 1'b0, 1'b0, 2);   // R9 clamp to sixteen
        // Random pages
        for (int k = 0; k < 5; k++) begin
            run_page(1 + int'($urandom % 16), ($urandom % 4 == 0), $urandom % 2 == 1, 0);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule